// File: doc/BRIEF.md
# Three-Factor Gated Weight Updater

This block sits beside one layer of leaky integrate-and-fire neurons and trains the layer's weights while the layer runs. When a timestep begins, it samples the presynaptic spike vector, every neuron's membrane potential and a coded error value for every output neuron. If learning is on and the timestep index falls inside a configurable window, it marks each presynaptic row whose input spiked. It then rewrites those rows one at a time in the weight store. No per-synapse trace or spike history is kept: a row changes only in a timestep where its input fired.

Each weight moves by the membrane potential of its postsynaptic neuron, scaled by that neuron's error. The error is coded as zero or as a signed power of two. The product is therefore an arithmetic right shift, plus a further shift set by a learning-rate exponent, with an optional negation. No multiplier is used. The result saturates at the 16-bit signed limits, and the weights keep their format of 8 fractional bits.

The inference datapath reads weight rows through a combinational port that has no added stage. The updater writes a row only in a cycle where inference is not reading that same row.

Top module: `tf_weight_updater`

## Requirements
- R1: After reset every weight in every row reads as zero and no update is pending.
- R2: `inf_rd_data` shows the row addressed by `inf_rd_addr` in the same cycle, with no register between the store and the port.
- R3: A timestep is taken for learning only when, at a rising edge, `step_start` and `learn_en` are both high and `cfg_win_start <= step_idx < cfg_win_start + cfg_win_len`. Steps outside the window, and steps taken while `learn_en` is low, leave every weight unchanged. Driving `learn_en` low discards any pending rows.
- R4: Only rows j with `pre_spk[j]`=1 in the sampled step are modified. All other rows keep their value.
- R5: The error code of post neuron i is `err_code[5i+4:5i]`. Bit 4 is the nonzero flag, bit 3 is the sign (1 = negative) and bits 2:0 give the exponent k. For a nonzero code, weight (j,i) gains floor(V_i / 2^(k+lr)), where lr is `cfg_lr_shift`; the term is negated when the sign bit is 1. A zero-flag code leaves the weight unchanged.
- R6: The sum saturates to 32767 above and to -32768 below.
- R7: The potentials, error codes and learning rate are taken at the capture edge. Later changes on those inputs do not affect that step's updates.
- R8: A pending row is never written in a cycle where `inf_rd_en` is high with `inf_rd_addr` on that row. Other pending rows are still written in that cycle, and the held row is written once the read moves away.
- R9: One row is written per cycle, choosing the lowest-numbered pending row that is not being read. The first row is written at the rising edge that follows the capture edge.
- R10: A qualifying `step_start` that arrives while rows of the previous step are still pending is dropped, and it makes no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| learn_en | input | 1 | Learning enable; low gives pure inference |
| cfg_win_start | input | TS_W | First timestep of the learning window |
| cfg_win_len | input | TS_W | Number of timesteps in the window |
| cfg_lr_shift | input | 3 | Learning-rate right-shift exponent |
| step_start | input | 1 | One-cycle pulse at the start of a timestep |
| step_idx | input | TS_W | Index of the starting timestep |
| pre_spk | input | N_PRE | Presynaptic spike vector |
| vmem | input | N_POST*16 | Membrane potentials, signed Q8.8, neuron i at bits 16i+15:16i |
| err_code | input | N_POST*5 | Coded error per post neuron |
| inf_rd_en | input | 1 | Inference datapath reads a weight row this cycle |
| inf_rd_addr | input | ROW_W | Row read by inference |
| inf_rd_data | output | N_POST*16 | Weight row, post neuron i at bits 16i+15:16i |

## Verification
The arithmetic is tried with positive and negative potentials, including odd negative values where rounding toward minus infinity differs from truncation. It is also tried with each error sign, with the zero-flag code and with several exponent and learning-rate sums, which separates an error in shift amount, sign handling and flooring. Spike masks with single, sparse and full rows show whether non-spiking rows stay untouched. Timesteps just inside and just outside both window edges, under two window settings, catch off-by-one gating. Reads held on a pending row and reads on other rows, together with a second step sent while the first is still draining, show the write ordering, the read-hazard hold and the dropping of overlapping steps.

// File: rtl/tgw_pkg.sv
package tgw_pkg;

  localparam int WGT_W = 16;
  localparam int EXP_W = 3;
  localparam int LR_W  = 3;
  localparam int ERR_W = EXP_W + 2;

  typedef logic signed [WGT_W-1:0] wgt_t;
  typedef logic signed [WGT_W:0]   term_t;

  typedef struct packed {
    logic             nz;
    logic             neg;
    logic [EXP_W-1:0] k;
  } err_t;

  // V * (+/- 2^-k) * 2^-lr as a floor shift with an optional negation
  function automatic term_t delta_term(wgt_t v, err_t e, logic [LR_W-1:0] lr);
    logic [5:0] sh;
    term_t      m;
    sh = 6'(e.k) + 6'(lr);
    m  = $signed({v[WGT_W-1], v}) >>> sh;
    if (!e.nz) return '0;
    return e.neg ? -m : m;
  endfunction

  // add with clamp to the signed weight range
  function automatic wgt_t sat_add(wgt_t w, term_t t);
    logic signed [WGT_W+1:0] s;
    s = $signed({{2{w[WGT_W-1]}}, w}) + $signed({t[WGT_W], t});
    if (s[WGT_W+1:WGT_W-1] == 3'b000 || s[WGT_W+1:WGT_W-1] == 3'b111)
      return s[WGT_W-1:0];
    return s[WGT_W+1] ? {1'b1, {(WGT_W-1){1'b0}}} : {1'b0, {(WGT_W-1){1'b1}}};
  endfunction

endpackage

// File: rtl/tgw_gate.sv
module tgw_gate #(
  parameter int TS_W = 4
) (
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] win_start,
  input  logic [TS_W-1:0] win_len,
  output logic            hit
);
  logic [TS_W:0] win_end;

  assign win_end = {1'b0, win_start} + {1'b0, win_len};
  assign hit     = (ts >= win_start) && ({1'b0, ts} < win_end);
endmodule

// File: rtl/tgw_row_pick.sv
module tgw_row_pick #(
  parameter int N_PRE = 8,
  localparam int ROW_W = (N_PRE > 1) ? $clog2(N_PRE) : 1
) (
  input  logic             allow,
  input  logic [N_PRE-1:0] pending,
  input  logic             rd_en,
  input  logic [ROW_W-1:0] rd_addr,
  output logic             grant,
  output logic [ROW_W-1:0] row,
  output logic [N_PRE-1:0] row_mask,
  output logic             blocked
);
  logic [N_PRE-1:0] rd_mask;
  logic [N_PRE-1:0] eligible;

  assign rd_mask  = rd_en ? (N_PRE'(1) << rd_addr) : '0;
  assign eligible = pending & ~rd_mask;
  assign blocked  = |(pending & rd_mask);

  always_comb begin
    row = '0;
    for (int r = N_PRE - 1; r >= 0; r--) begin
      if (eligible[r]) row = ROW_W'(r);
    end
  end

  assign grant    = allow && (|eligible);
  assign row_mask = grant ? (N_PRE'(1) << row) : '0;
endmodule

// File: rtl/tgw_row_calc.sv
module tgw_row_calc import tgw_pkg::*; #(
  parameter int N_POST = 4
) (
  input  logic [N_POST*WGT_W-1:0] row_in,
  input  logic [N_POST*WGT_W-1:0] vm,
  input  logic [N_POST*ERR_W-1:0] err,
  input  logic [LR_W-1:0]         lr,
  output logic [N_POST*WGT_W-1:0] row_out
);
  for (genvar i = 0; i < N_POST; i++) begin : g_post
    wgt_t  w_old;
    wgt_t  v_i;
    err_t  e_i;
    term_t t_i;
    assign w_old = row_in[i*WGT_W +: WGT_W];
    assign v_i   = vm[i*WGT_W +: WGT_W];
    assign e_i   = err_t'(err[i*ERR_W +: ERR_W]);
    assign t_i   = delta_term(v_i, e_i, lr);
    assign row_out[i*WGT_W +: WGT_W] = sat_add(w_old, t_i);
  end
endmodule

// File: rtl/tgw_wstore.sv
module tgw_wstore #(
  parameter int N_PRE  = 8,
  parameter int ROW_B  = 64,
  localparam int ROW_W = (N_PRE > 1) ? $clog2(N_PRE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [ROW_B-1:0] wr_data,
  input  logic [ROW_W-1:0] rd_a_addr,
  output logic [ROW_B-1:0] rd_a_data,
  input  logic [ROW_W-1:0] rd_b_addr,
  output logic [ROW_B-1:0] rd_b_data
);
  logic [ROW_B-1:0] mem [N_PRE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_PRE; r++) mem[r] <= '0;
    end else if (wr_en) begin
      mem[wr_row] <= wr_data;
    end
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/tf_weight_updater.sv
module tf_weight_updater import tgw_pkg::*; #(
  parameter int N_PRE  = 8,
  parameter int N_POST = 4,
  parameter int TS_W   = 4,
  localparam int ROW_W = (N_PRE > 1) ? $clog2(N_PRE) : 1,
  localparam int ROW_B = N_POST * WGT_W,
  localparam int ERR_B = N_POST * ERR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             learn_en,
  input  logic [TS_W-1:0]  cfg_win_start,
  input  logic [TS_W-1:0]  cfg_win_len,
  input  logic [LR_W-1:0]  cfg_lr_shift,
  input  logic             step_start,
  input  logic [TS_W-1:0]  step_idx,
  input  logic [N_PRE-1:0] pre_spk,
  input  logic [ROW_B-1:0] vmem,
  input  logic [ERR_B-1:0] err_code,
  input  logic             inf_rd_en,
  input  logic [ROW_W-1:0] inf_rd_addr,
  output logic [ROW_B-1:0] inf_rd_data
);
  // named internal events
  logic             win_hit;
  logic             busy;
  logic             capture;
  logic             step_dropped;
  logic             row_blocked;
  logic             wr_en;
  logic [ROW_W-1:0] wr_row;
  logic [N_PRE-1:0] wr_mask;
  logic [N_PRE-1:0] pending;

  logic [ROW_B-1:0] v_q;
  logic [ERR_B-1:0] e_q;
  logic [LR_W-1:0]  lr_q;
  logic [ROW_B-1:0] upd_old;
  logic [ROW_B-1:0] upd_new;

  tgw_gate #(.TS_W(TS_W)) u_gate (
    .ts        (step_idx),
    .win_start (cfg_win_start),
    .win_len   (cfg_win_len),
    .hit       (win_hit)
  );

  assign busy         = |pending;
  assign capture      = step_start && learn_en && win_hit && !busy;
  assign step_dropped = step_start && learn_en && win_hit && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      v_q     <= '0;
      e_q     <= '0;
      lr_q    <= '0;
    end else if (!learn_en) begin
      pending <= '0;
    end else if (capture) begin
      pending <= pre_spk;
      v_q     <= vmem;
      e_q     <= err_code;
      lr_q    <= cfg_lr_shift;
    end else begin
      pending <= pending & ~wr_mask;
    end
  end

  tgw_row_pick #(.N_PRE(N_PRE)) u_pick (
    .allow    (learn_en),
    .pending  (pending),
    .rd_en    (inf_rd_en),
    .rd_addr  (inf_rd_addr),
    .grant    (wr_en),
    .row      (wr_row),
    .row_mask (wr_mask),
    .blocked  (row_blocked)
  );

  tgw_row_calc #(.N_POST(N_POST)) u_calc (
    .row_in  (upd_old),
    .vm      (v_q),
    .err     (e_q),
    .lr      (lr_q),
    .row_out (upd_new)
  );

  tgw_wstore #(.N_PRE(N_PRE), .ROW_B(ROW_B)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_row    (wr_row),
    .wr_data   (upd_new),
    .rd_a_addr (inf_rd_addr),
    .rd_a_data (inf_rd_data),
    .rd_b_addr (wr_row),
    .rd_b_data (upd_old)
  );
endmodule

// File: rtl/tgw_checker.sv
module tgw_checker #(
  parameter int N_PRE = 8,
  localparam int ROW_W = (N_PRE > 1) ? $clog2(N_PRE) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             learn_en,
  input logic             step_start,
  input logic             inf_rd_en,
  input logic [ROW_W-1:0] inf_rd_addr,
  input logic             capture,
  input logic             step_dropped,
  input logic             row_blocked,
  input logic             wr_en,
  input logic [ROW_W-1:0] wr_row,
  input logic [N_PRE-1:0] pending
);
  a_r8_no_row_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inf_rd_en) |-> (wr_row != inf_rd_addr));

  a_r8_blocked_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (row_blocked && wr_en) |-> (wr_row != inf_rd_addr));

  a_r3_capture_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (learn_en && step_start));

  a_r3_unlearn_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !learn_en |=> (pending == '0));

  a_r4_write_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pending[wr_row]);

  a_r10_dropped_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    step_dropped |=> !$rose(capture));

  a_r9_one_row_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && learn_en) |=>
      (($countones($past(pending)) - $countones(pending)) >= 0) &&
      (($countones($past(pending)) - $countones(pending)) <= 1));
endmodule

bind tf_weight_updater tgw_checker #(.N_PRE(N_PRE)) u_chk (.*);

// File: tb/sim_tf_weight_updater.sv
module sim_tf_weight_updater;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NQ = 4;
  localparam int RB = NQ * 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          learn_en = 1'b0;
  logic [3:0]    cfg_win_start = 4'd5;
  logic [3:0]    cfg_win_len = 4'd5;
  logic [2:0]    cfg_lr_shift = 3'd0;
  logic          step_start = 1'b0;
  logic [3:0]    step_idx = 4'd0;
  logic [NP-1:0] pre_spk = '0;
  logic [RB-1:0] vmem = '0;
  logic [NQ*5-1:0] err_code = '0;
  logic          inf_rd_en = 1'b0;
  logic [2:0]    inf_rd_addr = '0;
  logic [RB-1:0] inf_rd_data;

  tf_weight_updater #(.N_PRE(NP), .N_POST(NQ), .TS_W(4)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int model [NP][NQ];

  typedef struct { logic [RB-1:0] row; string tag; } item_t;
  item_t sb [$];

  // ---------- reference arithmetic, restated ----------
  function automatic int ref_term(int v, bit nz, bit neg, int k, int lr);
    int p, q;
    if (!nz) return 0;
    p = 1 << (k + lr);
    if (v >= 0) q = v / p;
    else        q = -((-v + p - 1) / p);
    return neg ? -q : q;
  endfunction

  function automatic int clamp16(int x);
    if (x > 32767)  return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  function automatic logic [RB-1:0] pack_row(int r);
    logic [RB-1:0] p;
    for (int i = 0; i < NQ; i++) p[i*16 +: 16] = 16'(model[r][i]);
    return p;
  endfunction

  function automatic logic [4:0] ec(bit nz, bit neg, int k);
    return {nz, neg, 3'(k)};
  endfunction

  int sv [NQ];
  logic [4:0] se [NQ];

  function automatic void apply_model(logic [NP-1:0] mask, int lr);
    for (int r = 0; r < NP; r++)
      if (mask[r])
        for (int i = 0; i < NQ; i++)
          model[r][i] = clamp16(model[r][i] +
                        ref_term(sv[i], se[i][4], se[i][3], int'(se[i][2:0]), lr));
  endfunction

  // ---------- driver ----------
  task automatic drive_step(int ts, logic [NP-1:0] mask, int lr);
    step_start   = 1'b1;
    step_idx     = 4'(ts);
    pre_spk      = mask;
    cfg_lr_shift = 3'(lr);
    for (int i = 0; i < NQ; i++) begin
      vmem[i*16 +: 16]  = 16'(sv[i]);
      err_code[i*5 +: 5] = se[i];
    end
  endtask

  task automatic end_step();
    @(posedge clk); #1;
    step_start = 1'b0;
    pre_spk    = '1;
    vmem       = {RB/16{16'h7abc}};        // scrambled after capture (R7)
    err_code   = {NQ{5'b10000}};
    cfg_lr_shift = 3'd0;
  endtask

  task automatic full_step(int ts, logic [NP-1:0] mask, int lr, bit taken);
    @(posedge clk); #1;
    drive_step(ts, mask, lr);
    end_step();
    if (taken) apply_model(mask, lr);
    repeat (NP + 3) @(posedge clk);
  endtask

  task automatic push_read(int r, logic [RB-1:0] exp_row, string tag);
    item_t it;
    inf_rd_en   = 1'b1;
    inf_rd_addr = 3'(r);
    it.row = exp_row;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic read_row(int r, string tag);
    @(posedge clk); #1;
    push_read(r, pack_row(r), tag);
  endtask

  task automatic stop_read();
    @(posedge clk); #1;
    inf_rd_en = 1'b0;
  endtask

  task automatic read_all(string tag);
    for (int r = 0; r < NP; r++) read_row(r, tag);
    stop_read();
  endtask

  // ---------- monitor ----------
  always @(negedge clk) begin
    if (inf_rd_en) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL scoreboard empty: row %0d actual %h expected none", inf_rd_addr, inf_rd_data);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (inf_rd_data !== it.row) begin
          errors++;
          $display("FAIL %s row %0d: actual %h expected %h", it.tag, inf_rd_addr, inf_rd_data, it.row);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [RB-1:0] old_a, old_b;
    for (int r = 0; r < NP; r++) for (int i = 0; i < NQ; i++) model[r][i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R2: reset contents, same-cycle read port
    read_all("R1 R2 reset row");
    learn_en = 1'b1;

    // R4 / R5: sparse mask, mixed signs, zero-flag code
    sv = '{1000, -1000, 300, 77};
    se = '{ec(1,0,0), ec(1,1,1), ec(1,0,2), ec(0,1,3)};
    full_step(5, 8'b0000_0101, 1, 1'b1);
    read_all("R4 R5 basic update");

    // R5: odd negative potentials, floor rounding
    sv = '{-7, -1, 7, -32768};
    se = '{ec(1,0,1), ec(1,0,0), ec(1,1,1), ec(1,0,4)};
    full_step(9, 8'b1000_0010, 2, 1'b1);
    read_all("R5 floor rounding");

    // R3: just outside both window edges, then learning off
    sv = '{4000, 4000, 4000, 4000};
    se = '{ec(1,0,0), ec(1,0,0), ec(1,0,0), ec(1,0,0)};
    full_step(4, 8'hFF, 0, 1'b0);
    full_step(10, 8'hFF, 0, 1'b0);
    learn_en = 1'b0;
    full_step(6, 8'hFF, 0, 1'b0);
    learn_en = 1'b1;
    read_all("R3 gated off");

    // R3: another window, inside and just past it
    cfg_win_start = 4'd0;
    cfg_win_len   = 4'd3;
    sv = '{256, -256, 512, 128};
    se = '{ec(1,0,0), ec(1,0,1), ec(1,1,0), ec(1,0,0)};
    full_step(2, 8'b0001_0000, 0, 1'b1);
    full_step(3, 8'b0010_0000, 0, 1'b0);
    read_all("R3 window moved");
    cfg_win_start = 4'd5;
    cfg_win_len   = 4'd5;

    // R10 / R7: second step while first still draining is dropped
    sv = '{100, 200, -300, 400};
    se = '{ec(1,0,0), ec(1,0,0), ec(1,0,0), ec(1,1,0)};
    @(posedge clk); #1;
    drive_step(6, 8'hFF, 0);
    @(posedge clk); #1;
    sv = '{9000, 9000, 9000, 9000};
    drive_step(7, 8'hFF, 0);
    end_step();
    sv = '{100, 200, -300, 400};
    apply_model(8'hFF, 0);
    repeat (NP + 3) @(posedge clk);
    read_all("R10 R7 overlapping step");

    // R3: dropping learn_en discards pending rows
    sv = '{1111, 1111, 1111, 1111};
    se = '{ec(1,0,0), ec(1,0,0), ec(1,0,0), ec(1,0,0)};
    @(posedge clk); #1;
    drive_step(7, 8'b0001_0000, 0);
    @(posedge clk); #1;
    step_start = 1'b0;
    learn_en   = 1'b0;
    @(posedge clk); #1;
    learn_en = 1'b1;
    repeat (NP + 3) @(posedge clk);
    read_all("R3 learn_en drop");

    // R9: first write one edge after capture, lowest row first
    sv = '{50, 60, 70, 80};
    se = '{ec(1,0,0), ec(1,1,0), ec(1,0,1), ec(1,1,1)};
    old_b = pack_row(3);
    @(posedge clk); #1;
    drive_step(8, 8'b0000_1010, 0);
    end_step();                              // capture edge passed
    push_read(7, pack_row(7), "R9 unrelated row");
    apply_model(8'b0000_1010, 0);
    @(posedge clk); #1;                      // row 1 written at this edge
    push_read(3, old_b, "R9 row3 not yet written");
    @(posedge clk); #1;
    push_read(1, pack_row(1), "R9 row1 written first");
    stop_read();
    repeat (NP) @(posedge clk);
    read_row(3, "R9 row3 written later");
    stop_read();

    // R8: held read on a pending row blocks only that row
    sv = '{-2000, 3000, -4000, 5000};
    se = '{ec(1,1,2), ec(1,0,3), ec(1,0,0), ec(1,1,0)};
    old_a = pack_row(2);
    @(posedge clk); #1;
    drive_step(5, 8'b0010_0100, 0);
    push_read(2, old_a, "R8 held row before capture");
    @(posedge clk); #1;
    step_start = 1'b0;
    for (int c = 0; c < 5; c++) begin
      push_read(2, old_a, "R8 held row unchanged");
      @(posedge clk); #1;
    end
    inf_rd_en = 1'b0;
    apply_model(8'b0010_0100, 0);
    old_b = pack_row(5);
    repeat (NP) @(posedge clk);
    read_row(2, "R8 held row written after release");
    read_row(5, "R8 other row written during hold");
    stop_read();

    // R6: saturation at both limits
    sv = '{32767, -32768, 20000, -20000};
    se = '{ec(1,0,0), ec(1,0,0), ec(1,0,0), ec(1,0,0)};
    full_step(6, 8'b0100_0000, 0, 1'b1);
    full_step(7, 8'b0100_0000, 0, 1'b1);
    checks++;
    if (model[6][0] != 32767 || model[6][1] != -32768) begin
      errors++;
      $display("FAIL R6 model limits: actual %0d %0d expected 32767 -32768", model[6][0], model[6][1]);
    end
    read_all("R6 saturation");

    repeat (4) @(posedge clk);
    if (sb.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard leftover: actual %0d expected 0", sb.size());
    end
    finish_run();
  end
endmodule